// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block watches over software. A single write port carries an arm bit and a small key. A write with the arm bit set starts the watchdog from the stopped state. Once running, software must serve the watchdog before a first interval runs out. Serving takes one of two forms. A kick restarts the interval. A halt stops the watchdog. Both forms need the written key to be the bitwise inverse of the stored key, so a runaway loop that keeps writing one value cannot keep the watchdog quiet. A write with any other key only replaces the stored key.

If the first interval runs out, the block raises a non-maskable interrupt request. Software can still recover during a short grace interval by kicking or halting. If the grace interval also runs out, the block gives a one-cycle chip-reset pulse and returns to the stopped state. The lengths of both intervals are set in clock cycles by parameters.

The control FSM has four states. STOPPED is the reset state. ARMED is the first interval. ALARM is the grace interval, with the interrupt request raised. BITE is the reset pulse. The named transitions are:
- start: STOPPED to ARMED.
- kick: ARMED or ALARM to ARMED.
- halt: ARMED or ALARM to STOPPED.
- rekey: a self-loop that only updates the key.
- expire: ARMED to ALARM.
- bite: ALARM to BITE.
- release: BITE to STOPPED.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is stopped, `nmi_req` and `chip_rst` are low, and they stay low while no write occurs.
- R2: While stopped, a write with `wr_arm`=0 has no effect: no output changes and the watchdog stays stopped.
- R3: While stopped, a write with `wr_arm`=1 starts the watchdog and stores `wr_key`. If nothing else is written, `nmi_req` rises FIRST_CYCLES clock cycles after the write edge.
- R4: While running, a write with `wr_arm`=1 and `wr_key` equal to the bitwise NOT of the stored key is a kick. It stores `wr_key` and restarts the first interval, so `nmi_req` next rises FIRST_CYCLES cycles after this write.
- R5: While running, a write with `wr_arm`=0 and `wr_key` equal to the bitwise NOT of the stored key is a halt. It stops the watchdog, and no interrupt or reset follows.
- R6: While running, a write whose key is not the bitwise NOT of the stored key only replaces the stored key, for either value of `wr_arm`. The timer and the state are left unchanged.
- R7: `nmi_req` stays high until a kick, a halt or the reset pulse. If the watchdog is not served, `chip_rst` goes high for exactly one cycle GRACE_CYCLES cycles after `nmi_req` rose, and `nmi_req` falls in that same cycle.
- R8: After the reset pulse the watchdog is stopped, and no further interrupt or reset occurs without a new start.
- R9: A kick or a halt during the grace interval drops `nmi_req` on the next cycle and cancels the pending reset.
- R10: A write sampled in the cycle where `chip_rst` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_arm | input | 1 | Arm bit of the control word |
| wr_key | input | KEY_W | Key field of the control word |
| nmi_req | output | 1 | Non-maskable interrupt request, high during the grace interval |
| chip_rst | output | 1 | One-cycle chip-reset pulse |

## Verification
The assertions assume that `wr_en`, `wr_arm` and `wr_key` are stable around each rising edge. They also assume that `wr_arm` and `wr_key` matter only in a cycle where `wr_en` is high. The assertions place no other limit on write order, so kicks, halts and wrong keys may arrive in any state. The stimulus changes inputs only on falling edges and holds each write for exactly one cycle. It times each grace-interval write so that it lands strictly inside that interval, and it sends the write that R10 needs exactly in the cycle of the reset pulse.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Control FSM states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // STOPPED
        ST_ARMED = 2'd1,   // first interval running
        ST_ALARM = 2'd2,   // grace interval, interrupt raised
        ST_FIRE  = 2'd3    // one-cycle reset pulse (BITE)
    } wdg_state_e;

    // Decoded meaning of a control write
    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_START = 3'd1,
        CMD_KICK  = 3'd2,
        CMD_HALT  = 3'd3,
        CMD_REKEY = 3'd4
    } wdg_cmd_e;

endpackage

// File: rtl/wdg_cmd_decode.sv
module wdg_cmd_decode #(
    parameter int KEY_W = 3
) (
    input  logic                 running,
    input  logic                 wr_en,
    input  logic                 wr_arm,
    input  logic [KEY_W-1:0]     wr_key,
    input  logic [KEY_W-1:0]     stored_key,
    output wdg_pkg::wdg_cmd_e    cmd
);
    import wdg_pkg::*;

    logic key_inverse;

    always_comb begin
        key_inverse = (wr_key == ~stored_key);
        if (!wr_en) begin
            cmd = CMD_NONE;
        end else if (!running) begin
            cmd = wr_arm ? CMD_START : CMD_NONE;
        end else if (key_inverse) begin
            cmd = wr_arm ? CMD_KICK : CMD_HALT;
        end else begin
            cmd = CMD_REKEY;
        end
    end

endmodule

// File: rtl/wdg_span_timer.sv
module wdg_span_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = run && (cnt_q == '0);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
    parameter int KEY_W        = 3,
    parameter int FIRST_CYCLES = 5_000_000,
    parameter int GRACE_CYCLES = 165_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_arm,
    input  logic [KEY_W-1:0] wr_key,
    output logic             nmi_req,
    output logic             chip_rst
);
    import wdg_pkg::*;

    localparam int SPAN_MAX = (FIRST_CYCLES > GRACE_CYCLES) ? FIRST_CYCLES : GRACE_CYCLES;
    localparam int CNT_W    = (SPAN_MAX > 1) ? $clog2(SPAN_MAX) : 1;
    localparam logic [CNT_W-1:0] FIRST_LOAD = CNT_W'(FIRST_CYCLES - 1);
    localparam logic [CNT_W-1:0] GRACE_LOAD = CNT_W'(GRACE_CYCLES - 1);

    wdg_state_e       state_q, state_d;
    logic [KEY_W-1:0] key_q, key_d;
    logic             running;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    wdg_cmd_e         cmd;

    assign running = (state_q == ST_ARMED) || (state_q == ST_ALARM);

    wdg_cmd_decode #(.KEY_W(KEY_W)) u_decode (
        .running    (running),
        .wr_en      (wr_en),
        .wr_arm     (wr_arm),
        .wr_key     (wr_key),
        .stored_key (key_q),
        .cmd        (cmd)
    );

    wdg_span_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // Next-state, key and timer control
    always_comb begin
        state_d  = state_q;
        key_d    = key_q;
        tmr_load = 1'b0;
        tmr_val  = FIRST_LOAD;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd == CMD_START) begin          // start
                    state_d  = ST_ARMED;
                    key_d    = wr_key;
                    tmr_load = 1'b1;
                end
            end
            ST_ARMED, ST_ALARM: begin
                if (cmd == CMD_HALT) begin           // halt
                    state_d = ST_IDLE;
                    key_d   = wr_key;
                end else if (cmd == CMD_KICK) begin  // kick
                    state_d  = ST_ARMED;
                    key_d    = wr_key;
                    tmr_load = 1'b1;
                end else begin
                    if (cmd == CMD_REKEY) begin      // rekey
                        key_d = wr_key;
                    end
                    if (tmr_expired) begin
                        if (state_q == ST_ARMED) begin   // expire
                            state_d  = ST_ALARM;
                            tmr_load = 1'b1;
                            tmr_val  = GRACE_LOAD;
                        end else begin                   // bite
                            state_d = ST_FIRE;
                        end
                    end
                end
            end
            ST_FIRE: begin                           // release
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            key_q   <= '0;
        end else begin
            state_q <= state_d;
            key_q   <= key_d;
        end
    end

    // Outputs
    always_comb begin
        nmi_req  = (state_q == ST_ALARM);
        chip_rst = (state_q == ST_FIRE);
    end

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
    parameter int KEY_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 wr_arm,
    input logic [KEY_W-1:0]     wr_key,
    input wdg_pkg::wdg_state_e  state,
    input logic [KEY_W-1:0]     stored_key,
    input logic                 nmi_req,
    input logic                 chip_rst
);
    import wdg_pkg::*;

    logic live;
    assign live = (state == ST_ARMED) || (state == ST_ALARM);

    // R2
    idle_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_en && !wr_arm) |=> (state == ST_IDLE && !nmi_req && !chip_rst));

    // R3
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_en && wr_arm) |=> (state == ST_ARMED && stored_key == $past(wr_key)));

    // R6
    key_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && wr_en) |=> (stored_key == $past(wr_key)));

    // R5
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && wr_en && !wr_arm && wr_key == ~stored_key) |=> (state == ST_IDLE && !nmi_req && !chip_rst));

    // R7
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst |=> !chip_rst);

    // R7
    bite_after_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_rst) |-> $past(nmi_req));

    // R9
    grace_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && wr_en && wr_arm && wr_key == ~stored_key) |=> (!nmi_req && !chip_rst));

    // R10
    fire_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst |=> (state == ST_IDLE && !nmi_req));

endmodule

bind keyed_watchdog wdg_checker #(.KEY_W(KEY_W)) u_wdg_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_arm     (wr_arm),
    .wr_key     (wr_key),
    .state      (state_q),
    .stored_key (key_q),
    .nmi_req    (nmi_req),
    .chip_rst   (chip_rst)
);

// File: tb/test_keyed_watchdog.sv
`timescale 1ns/1ps
module test_keyed_watchdog;
    localparam int KW = 3;
    localparam int F  = 24;
    localparam int G  = 7;

    typedef enum int {EV_NMI_ON, EV_NMI_OFF, EV_RST_ON, EV_RST_OFF} ev_e;
    typedef struct {
        ev_e   kind;
        int    at;
        string req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_arm = 1'b0;
    logic [KW-1:0] wr_key = '0;
    logic          nmi_req, chip_rst;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    ended = 1'b0;
    string cur_req = "R1";
    exp_t  sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    keyed_watchdog #(.KEY_W(KW), .FIRST_CYCLES(F), .GRACE_CYCLES(G)) i_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_arm(wr_arm), .wr_key(wr_key),
        .nmi_req(nmi_req), .chip_rst(chip_rst)
    );

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Monitor: pops expectations as output edges appear
    task automatic observe(ev_e kind);
        exp_t e;
        if (sb.size() == 0) begin
            check(1'b0, cur_req, "unexpected output event kind", int'(kind), -1);
        end else begin
            e = sb.pop_front();
            check(e.kind == kind, e.req, "event kind", int'(kind), int'(e.kind));
            check(e.at == cyc, e.req, "event cycle", cyc, e.at);
        end
    endtask

    logic nmi_prev = 1'b0;
    logic rst_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (nmi_req && !nmi_prev)   observe(EV_NMI_ON);
            if (!nmi_req && nmi_prev)   observe(EV_NMI_OFF);
            if (chip_rst && !rst_prev)  observe(EV_RST_ON);
            if (!chip_rst && rst_prev)  observe(EV_RST_OFF);
            nmi_prev = nmi_req;
            rst_prev = chip_rst;
        end
    end

    // Driver
    task automatic put(bit arm, logic [KW-1:0] k, output int e);
        @(negedge clk);
        wr_en  = 1'b1;
        wr_arm = arm;
        wr_key = k;
        e = cyc;
    endtask

    task automatic done_wr();
        @(negedge clk);
        wr_en  = 1'b0;
        wr_arm = 1'b0;
        wr_key = '0;
    endtask

    task automatic expect_ev(ev_e k, int at, string r);
        exp_t e;
        e.kind = k;
        e.at   = at;
        e.req  = r;
        sb.push_back(e);
    endtask

    task automatic wait_to(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic drain(int extra, string r);
        cur_req = r;
        repeat (extra) @(negedge clk);
        check(sb.size() == 0, r, "expected events still pending", sb.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, cur_req, "watchdog expired, cycle", cyc, 200000);
        finish_run();
    end

    initial begin
        int e0, e1, e2, e3, e4;

        // R1: reset state
        repeat (5) @(negedge clk);
        check(nmi_req == 1'b0, "R1", "nmi_req in reset", nmi_req, 0);
        check(chip_rst == 1'b0, "R1", "chip_rst in reset", chip_rst, 0);
        rst_n = 1'b1;
        drain(2 * (F + G), "R1");

        // R2: stopped, arm=0 write has no effect
        cur_req = "R2";
        put(1'b0, 3'd3, e0);
        done_wr();
        drain(2 * (F + G), "R2");

        // R3, R7, R8, R10: start and let it run out
        put(1'b1, 3'd3, e0);
        expect_ev(EV_NMI_ON,  e0 + 1 + F,     "R3");
        expect_ev(EV_NMI_OFF, e0 + 1 + F + G, "R7");
        expect_ev(EV_RST_ON,  e0 + 1 + F + G, "R7");
        expect_ev(EV_RST_OFF, e0 + 2 + F + G, "R7");
        done_wr();
        wait_to(e0 + F + G);
        cur_req = "R10";
        put(1'b1, 3'd5, e1);   // lands in the reset-pulse cycle
        check(e1 == e0 + 1 + F + G, "R10", "write cycle alignment", e1, e0 + 1 + F + G);
        done_wr();
        drain(2 * (F + G), "R8");

        // R4 kick in first interval, R9 halt in grace
        put(1'b1, 3'd3, e0);
        done_wr();
        wait_to(e0 + F / 2);
        put(1'b1, 3'd4, e1);   // ~3 = 4
        expect_ev(EV_NMI_ON, e1 + 1 + F, "R4");
        done_wr();
        wait_to(e1 + F + 5);
        put(1'b0, 3'd3, e2);   // ~4 = 3, halt during grace
        expect_ev(EV_NMI_OFF, e2 + 1, "R9");
        done_wr();
        drain(2 * (F + G), "R9");

        // R5: halt in first interval
        put(1'b1, 3'd6, e0);
        done_wr();
        wait_to(e0 + 5);
        put(1'b0, 3'd1, e1);   // ~6 = 1
        done_wr();
        drain(2 * (F + G), "R5");

        // R6: wrong keys only rekey; R9 kick in grace; R7 reset after wrong key in grace
        put(1'b1, 3'd1, e0);
        expect_ev(EV_NMI_ON, e0 + 1 + F, "R6");
        done_wr();
        wait_to(e0 + 4);
        put(1'b0, 3'd2, e1);   // not ~1: no halt, key becomes 2
        done_wr();
        wait_to(e0 + 8);
        put(1'b1, 3'd0, e2);   // not ~2: no kick, key becomes 0
        done_wr();
        wait_to(e0 + F + 2);
        put(1'b1, 3'd7, e3);   // ~0 = 7: kick during grace
        expect_ev(EV_NMI_OFF, e3 + 1,     "R9");
        expect_ev(EV_NMI_ON,  e3 + 1 + F, "R4");
        expect_ev(EV_NMI_OFF, e3 + 1 + F + G, "R6");
        expect_ev(EV_RST_ON,  e3 + 1 + F + G, "R7");
        expect_ev(EV_RST_OFF, e3 + 2 + F + G, "R7");
        done_wr();
        wait_to(e3 + F + 3);
        put(1'b1, 3'd1, e4);   // not ~7: rekey only, reset still follows
        done_wr();
        drain(2 * (F + G), "R6");

        finish_run();
    end

endmodule